// File: doc/BRIEF.md
# Hot-Insertion Two-Wire Link Controller

This block decides when a card that has just been plugged into a live backplane may join its two-wire serial bus (data and clock) to the backplane bus. It sees a supply-good flag, an active-low connection-enable input, and the levels of both buses on both sides. After power is good it assumes the card arrived in the middle of a transfer. It therefore waits for the backplane to finish, either by a stop condition or by a quiet interval of configurable length. It also requires both card lines to be high. Only then does it close the link.

While linked, the block imitates an open-drain bidirectional coupling in digital form. When one side of a line is pulled low, the block drives a pull-down enable on the other side. It releases that pull-down when the originating side lets go. Data and clock are handled separately. A status pull-down (the READY flag, open-drain) and a precharge enable report whether the sides are joined. Raising the enable input or losing supply-good drops the link at once and restarts the wait.

Top module: `hsb_link_ctrl`

## Requirements
- R1: While `pwr_good` is low, the block stays unlinked: `ready_pd` is 1, `precharge_en` is 1 and all four line pull-downs are 0, whatever the buses do. If power drops while linked, the link opens on the next clock.
- R2: Once powered and enabled, the block links after a stop condition on the backplane, that is, backplane data rising while backplane clock is high. Both card lines must also read high.
- R3: The block also links after `IDLE_CYCLES` consecutive clocks in which both backplane lines are high and unchanged. Any edge or low level on either backplane line restarts this count.
- R4: If either card line reads low at the qualifying moment, the block does not link and keeps waiting. Once the card lines are high again, a still-valid idle condition links it.
- R5: A high (synchronized) `cs_in` opens the link within three clocks, with `ready_pd` set to 1. No stop or idle condition links while `cs_in` is high.
- R6: When `cs_in` returns low, the wait sequence restarts and the idle count starts from zero.
- R7: `ready_pd` is 0 and `precharge_en` is 0 exactly while linked. Both are 1 otherwise.
- R8: While linked, a side that pulls a line low first becomes the owner of that line, and the opposite side's pull-down goes to 1. It goes back to 0 after the owner releases. If the other side is still held low after a guard time of `SYNC_STAGES+1` clocks, ownership passes to it. SDA and SCL behave independently.
- R9: No pull-down is 1 while unlinked, and the two pull-downs of one line are never 1 together.
- R10: Every line and enable input passes through a `SYNC_STAGES`-flop synchronizer (default 2), which resets to the high (released or disabled) level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good flag, synchronous |
| cs_in | input | 1 | Connection enable, high disconnects |
| bp_sda_in | input | 1 | Backplane data line level |
| bp_scl_in | input | 1 | Backplane clock line level |
| cd_sda_in | input | 1 | Card data line level |
| cd_scl_in | input | 1 | Card clock line level |
| bp_sda_pd | output | 1 | Pull-down enable, backplane data |
| bp_scl_pd | output | 1 | Pull-down enable, backplane clock |
| cd_sda_pd | output | 1 | Pull-down enable, card data |
| cd_scl_pd | output | 1 | Pull-down enable, card clock |
| ready_pd | output | 1 | Status pull-down, 1 while not linked |
| precharge_en | output | 1 | Precharge enable, 1 while not linked |

## Verification
The bench drives a clock line that toggles faster than the idle interval. A design that failed to restart its idle count on each edge would link in the middle of that traffic. It then holds a card line low across a saturated idle count, so a design that skipped the card check would link onto a busy card. A stop condition sent while the enable is high catches a design that still listens when disabled. A case where both sides hold the same line low, with the original owner releasing first, catches two faults: a design that never hands ownership over would leave the line released while a card device still holds it, and a design without the guard time would drive both pull-downs together.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_LINK = 2'd2
  } link_st_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_BP   = 2'd1,
    OWN_CD   = 2'd2
  } own_e;

  // stop condition: data rises while clock stays high
  function automatic logic is_stop(input logic sda_now, input logic sda_was,
                                   input logic scl_now, input logic scl_was);
    return sda_now & ~sda_was & scl_now & scl_was;
  endfunction

  // bus counts as quiet when both lines are high and neither moved
  function automatic logic is_quiet(input logic sda_now, input logic sda_was,
                                    input logic scl_now, input logic scl_was);
    return sda_now & scl_now & (sda_now == sda_was) & (scl_now == scl_was);
  endfunction

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/hsb_idle_det.sv
module hsb_idle_det
  import hsb_pkg::*;
#(
  parameter int IDLE_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sda,
  input  logic scl,
  output logic stop_evt,
  output logic idle_hit
);

  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_CYCLES);

  logic          sda_q, scl_q;
  logic [CW-1:0] cnt;
  logic          quiet;

  assign stop_evt = is_stop(sda, sda_q, scl, scl_q);
  assign quiet    = is_quiet(sda, sda_q, scl, scl_q);
  assign idle_hit = (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
      cnt   <= '0;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
      if (!arm || !quiet) cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hsb_line_couple.sv
module hsb_line_couple
  import hsb_pkg::*;
#(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link,
  input  logic bp_lvl,
  input  logic cd_lvl,
  output logic bp_pd,
  output logic cd_pd
);

  localparam int HW = $clog2(HOLD + 1);

  own_e          owner;
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= OWN_NONE;
      hold  <= '0;
    end else if (!link) begin
      owner <= OWN_NONE;
      hold  <= '0;
    end else begin
      unique case (owner)
        OWN_NONE: begin
          if (hold != '0)  hold  <= hold - 1'b1;
          else if (!bp_lvl) owner <= OWN_BP;
          else if (!cd_lvl) owner <= OWN_CD;
        end
        OWN_BP: if (bp_lvl) begin
          owner <= OWN_NONE;
          hold  <= HW'(HOLD);
        end
        OWN_CD: if (cd_lvl) begin
          owner <= OWN_NONE;
          hold  <= HW'(HOLD);
        end
        default: owner <= OWN_NONE;
      endcase
    end
  end

  assign bp_pd = link && (owner == OWN_CD);
  assign cd_pd = link && (owner == OWN_BP);

endmodule

// File: rtl/hsb_link_ctrl.sv
module hsb_link_ctrl
  import hsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic cs_in,
  input  logic bp_sda_in,
  input  logic bp_scl_in,
  input  logic cd_sda_in,
  input  logic cd_scl_in,
  output logic bp_sda_pd,
  output logic bp_scl_pd,
  output logic cd_sda_pd,
  output logic cd_scl_pd,
  output logic ready_pd,
  output logic precharge_en
);

  localparam int NLINES = 2;
  localparam int HOLD   = SYNC_STAGES + 1;

  logic [4:0] sync_q;
  logic       s_cs, b_sda_s, b_scl_s, c_sda_s, c_scl_s;
  logic       stop_evt, idle_hit, arm, linked;
  link_st_e   st, st_nx;

  hsb_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cd_scl_in, cd_sda_in, bp_scl_in, bp_sda_in, cs_in}),
    .q(sync_q)
  );

  assign {c_scl_s, c_sda_s, b_scl_s, b_sda_s, s_cs} = sync_q;

  assign arm = (st == ST_WAIT) && !s_cs;

  hsb_idle_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .sda(b_sda_s), .scl(b_scl_s),
    .stop_evt(stop_evt), .idle_hit(idle_hit)
  );

  always_comb begin
    st_nx = st;
    if (!pwr_good) st_nx = ST_OFF;
    else begin
      unique case (st)
        ST_OFF:  st_nx = ST_WAIT;
        ST_WAIT: if (!s_cs && (stop_evt || idle_hit) && c_sda_s && c_scl_s)
                   st_nx = ST_LINK;
        ST_LINK: if (s_cs) st_nx = ST_WAIT;
        default: st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= st_nx;
  end

  assign linked = (st == ST_LINK);

  logic [NLINES-1:0] bp_lvl, cd_lvl, bp_pd_v, cd_pd_v;
  assign bp_lvl = {b_scl_s, b_sda_s};
  assign cd_lvl = {c_scl_s, c_sda_s};

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    hsb_line_couple #(.HOLD(HOLD)) u_couple (
      .clk(clk), .rst_n(rst_n), .link(linked),
      .bp_lvl(bp_lvl[k]), .cd_lvl(cd_lvl[k]),
      .bp_pd(bp_pd_v[k]), .cd_pd(cd_pd_v[k])
    );
  end

  assign bp_sda_pd    = bp_pd_v[0];
  assign bp_scl_pd    = bp_pd_v[1];
  assign cd_sda_pd    = cd_pd_v[0];
  assign cd_scl_pd    = cd_pd_v[1];
  assign ready_pd     = !linked;
  assign precharge_en = !linked;

endmodule

// File: rtl/hsb_link_chk.sv
module hsb_link_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic s_cs,
  input logic c_sda_s,
  input logic c_scl_s,
  input logic stop_evt,
  input logic idle_hit,
  input logic bp_sda_pd,
  input logic bp_scl_pd,
  input logic cd_sda_pd,
  input logic cd_scl_pd,
  input logic ready_pd,
  input logic precharge_en
);

  assert_no_pd_unlinked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_en |-> !(bp_sda_pd || bp_scl_pd || cd_sda_pd || cd_scl_pd));

  assert_one_side_per_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bp_sda_pd && cd_sda_pd) && !(bp_scl_pd && cd_scl_pd));

  assert_pwr_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (precharge_en && ready_pd));

  assert_cs_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs |=> ready_pd);

  assert_card_idle_at_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(precharge_en) |-> $past(c_sda_s && c_scl_s));

  assert_link_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(precharge_en) |-> $past(stop_evt || idle_hit));

  assert_ready_tracks_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_pd |-> !precharge_en);

endmodule

bind hsb_link_ctrl hsb_link_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .s_cs(s_cs),
  .c_sda_s(c_sda_s), .c_scl_s(c_scl_s), .stop_evt(stop_evt), .idle_hit(idle_hit),
  .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd), .cd_sda_pd(cd_sda_pd),
  .cd_scl_pd(cd_scl_pd), .ready_pd(ready_pd), .precharge_en(precharge_en)
);

// File: tb/hsb_link_ctrl_tb_top.sv
module hsb_link_ctrl_tb_top;

  localparam int IDLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic cs_in = 1'b0;
  logic ext_bp_sda = 1'b1, ext_bp_scl = 1'b1, ext_cd_sda = 1'b1, ext_cd_scl = 1'b1;
  logic bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd, ready_pd, precharge_en;
  wire  bp_sda_w = ext_bp_sda & ~bp_sda_pd;
  wire  bp_scl_w = ext_bp_scl & ~bp_scl_pd;
  wire  cd_sda_w = ext_cd_sda & ~cd_sda_pd;
  wire  cd_scl_w = ext_cd_scl & ~cd_scl_pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hsb_link_ctrl #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_in(cs_in),
    .bp_sda_in(bp_sda_w), .bp_scl_in(bp_scl_w),
    .cd_sda_in(cd_sda_w), .cd_scl_in(cd_scl_w),
    .bp_sda_pd(bp_sda_pd), .bp_scl_pd(bp_scl_pd),
    .cd_sda_pd(cd_sda_pd), .cd_scl_pd(cd_scl_pd),
    .ready_pd(ready_pd), .precharge_en(precharge_en)
  );

  // behavioural reference: 0 off, 1 waiting, 2 joined; owner 0 none, 1 backplane, 2 card
  bit [4:0] m_s1, m_s2;
  bit       m_psda, m_pscl;
  int       m_cnt, m_st;
  int       m_own [2];
  int       m_hold [2];
  bit       v_cs, v_bsda, v_bscl, v_csda, v_cscl, v_stop, v_quiet, v_hit, v_bp, v_cd;
  int       v_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '1; m_s2 = '1; m_psda = 1; m_pscl = 1; m_cnt = 0; m_st = 0;
      for (int k = 0; k < 2; k++) begin m_own[k] = 0; m_hold[k] = 0; end
    end else begin
      v_cs = m_s2[0]; v_bsda = m_s2[1]; v_bscl = m_s2[2]; v_csda = m_s2[3]; v_cscl = m_s2[4];
      v_stop  = v_bscl && m_pscl && v_bsda && !m_psda;
      v_quiet = v_bsda && v_bscl && (v_bsda == m_psda) && (v_bscl == m_pscl);
      v_hit   = (m_cnt == IDLE);
      for (int k = 0; k < 2; k++) begin
        v_bp = m_s2[1+k]; v_cd = m_s2[3+k];
        if (m_st != 2) begin m_own[k] = 0; m_hold[k] = 0; end
        else if (m_own[k] == 0) begin
          if (m_hold[k] > 0) m_hold[k]--;
          else if (!v_bp) m_own[k] = 1;
          else if (!v_cd) m_own[k] = 2;
        end else if (m_own[k] == 1 && v_bp) begin m_own[k] = 0; m_hold[k] = 3; end
        else if (m_own[k] == 2 && v_cd) begin m_own[k] = 0; m_hold[k] = 3; end
      end
      if (!(m_st == 1 && !v_cs) || !v_quiet) m_cnt = 0;
      else if (m_cnt < IDLE) m_cnt++;
      v_st = m_st;
      if (!pwr_good) v_st = 0;
      else if (m_st == 0) v_st = 1;
      else if (m_st == 1 && !v_cs && (v_stop || v_hit) && v_csda && v_cscl) v_st = 2;
      else if (m_st == 2 && v_cs) v_st = 1;
      m_st = v_st;
      m_psda = v_bsda; m_pscl = v_bscl;
      m_s2 = m_s1;
      m_s1 = {cd_scl_w, cd_sda_w, bp_scl_w, bp_sda_w, cs_in};
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference (R7 R8 R9 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit lk;
      lk = (m_st == 2);
      chk(ready_pd == !lk && precharge_en == !lk, "R7", "model ready/precharge",
          {ready_pd, precharge_en}, {!lk, !lk});
      chk(bp_sda_pd == (lk && m_own[0] == 2) && cd_sda_pd == (lk && m_own[0] == 1) &&
          bp_scl_pd == (lk && m_own[1] == 2) && cd_scl_pd == (lk && m_own[1] == 1),
          "R8", "model pull-downs {bpsda,cdsda,bpscl,cdscl}",
          {bp_sda_pd, cd_sda_pd, bp_scl_pd, cd_scl_pd},
          {(lk && m_own[0] == 2), (lk && m_own[0] == 1), (lk && m_own[1] == 2), (lk && m_own[1] == 1)});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_link(input bit want, input string req, input string what);
    chk(ready_pd == !want, req, {what, " ready_pd"}, ready_pd, !want);
    chk(precharge_en == !want, req, {what, " precharge_en"}, precharge_en, !want);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // reset state
    expect_link(0, "R7", "reset");
    chk({bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd} == 4'b0, "R9", "reset pull-downs",
        {bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd}, 0);

    // R1: power not good, stop and long idle are ignored
    ext_bp_sda = 0; cyc(5); ext_bp_sda = 1; cyc(IDLE + 30);
    expect_link(0, "R1", "power low");

    // R3: clock traffic faster than the idle interval keeps it waiting
    pwr_good = 1;
    for (int i = 0; i < 20; i++) begin
      ext_bp_scl = 0; cyc(5); ext_bp_scl = 1; cyc(5);
    end
    expect_link(0, "R3", "busy clock");

    // R2: stop condition links
    ext_bp_sda = 0; cyc(5); ext_bp_sda = 1; cyc(6);
    expect_link(1, "R2", "after stop");

    // R8: backplane pulls data low, card side follows
    ext_bp_sda = 0; cyc(5);
    chk(cd_sda_pd == 1, "R8", "card sda pd", cd_sda_pd, 1);
    chk(bp_sda_pd == 0 && cd_scl_pd == 0, "R8", "no echo / scl independent",
        {bp_sda_pd, cd_scl_pd}, 0);
    ext_bp_sda = 1; cyc(5);
    chk(cd_sda_pd == 0, "R8", "card sda released", cd_sda_pd, 0);

    // R8: wired-AND when both sides hold the clock low
    ext_bp_scl = 0; cyc(5);
    chk(cd_scl_pd == 1, "R8", "card scl pd", cd_scl_pd, 1);
    ext_cd_scl = 0; cyc(5);
    ext_bp_scl = 1; cyc(10);
    chk(bp_scl_pd == 1 && cd_scl_pd == 0, "R8", "ownership handed to card {bp,cd}",
        {bp_scl_pd, cd_scl_pd}, 2);
    ext_cd_scl = 1; cyc(6);
    chk(bp_scl_pd == 0, "R8", "backplane scl released", bp_scl_pd, 0);

    // R8: card pulls data low
    ext_cd_sda = 0; cyc(5);
    chk(bp_sda_pd == 1, "R8", "backplane sda pd", bp_sda_pd, 1);
    ext_cd_sda = 1; cyc(6);

    // R5: enable high breaks the link and blocks a stop
    cs_in = 1; cyc(4);
    expect_link(0, "R5", "cs high");
    ext_bp_sda = 0; cyc(5); ext_bp_sda = 1; cyc(IDLE + 10);
    expect_link(0, "R5", "stop while cs high");

    // R6: enable low restarts the wait; idle count starts from zero
    cs_in = 0; cyc(20);
    expect_link(0, "R6", "mid idle count");
    cyc(IDLE);
    expect_link(1, "R6", "idle after cs low");

    // R4: card line low blocks linking
    cs_in = 1; cyc(4);
    ext_cd_sda = 0; cs_in = 0; cyc(IDLE + 40);
    expect_link(0, "R4", "card low");
    ext_cd_sda = 1; cyc(6);
    expect_link(1, "R4", "card released");

    // R1: power drop while linked
    ext_bp_sda = 0; cyc(5);
    pwr_good = 0; cyc(2);
    expect_link(0, "R1", "power drop");
    chk(cd_sda_pd == 0, "R1", "pd dropped", cd_sda_pd, 0);
    ext_bp_sda = 1; cyc(2);
    pwr_good = 1; cyc(IDLE + 10);
    expect_link(1, "R3", "idle after power return");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule